// File: doc/BRIEF.md
# Packed Saturating Add/Subtract/Compare Unit

This block performs one lane-parallel integer operation on a pair of 64-bit operands. The operands are cut into eight 8-bit, four 16-bit or two 32-bit lanes. Each lane is added, subtracted or compared on its own, and no carry or borrow crosses a lane boundary. Out-of-range results are not reported through flags. Each lane either wraps, or is clamped to the limits of its signed or unsigned range. A compare fills a lane with ones when the condition is true and with zeros when it is false.

A caller presents operands and selects together with a one-cycle `in_valid` strobe. On the next clock edge the result is captured into a register, and during the following cycle it is shown with `out_valid` high. A select combination the unit does not support raises `illegal_op` and returns zero in place of a result.

Top module: `simd_sat_alu`

## Requirements
- R1: With `op`=0 (add) and `mode`=0 (wrap), each lane returns the sum of its operand lanes modulo 2^W, where W is 8, 16 or 32 for `size`=0, 1 or 2. No carry passes into the neighbouring lane.
- R2: With `op`=1 (subtract) and `mode`=0, each lane returns a-b modulo 2^W, and no borrow passes between lanes.
- R3: With `mode`=1 (signed clamp) and `size`=0 or 1, an add or subtract whose true signed result lies above 2^(W-1)-1 returns 2^(W-1)-1. One that lies below -2^(W-1) returns -2^(W-1). Any other result is returned exactly.
- R4: With `mode`=2 (unsigned clamp), `op`=0 and `size`=0 or 1, a lane whose unsigned sum exceeds 2^W-1 returns all ones.
- R5: With `mode`=2, `op`=1 and `size`=0 or 1, a lane whose difference would be negative returns zero.
- R6: With `op`=2 (equal), each lane returns all ones when its two operand lanes are equal and all zeros when they differ. `mode` is ignored, provided the combination is legal.
- R7: With `op`=3 (greater), each lane returns all ones when lane a, read as a two's-complement number, is greater than lane b, and all zeros otherwise.
- R8: If `size`=2 with `mode`≠0, or `size`=3, or `mode`=3, then `illegal_op` is 1 and `result` is zero. Any other combination gives `illegal_op`=0.
- R9: A strobe sampled on one clock edge makes `out_valid` high and updates `result`/`illegal_op` after that edge. When no strobe is sampled, `out_valid` goes low and `result` holds its value.
- R10: While reset is active, and after it is released, `out_valid`, `result` and `illegal_op` are all zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 add, 1 subtract, 2 equal, 3 signed greater |
| size | input | 2 | 0 byte, 1 16-bit, 2 32-bit lanes, 3 unsupported |
| mode | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 unsupported |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Packed lane results |
| illegal_op | output | 1 | Unsupported select combination |

## Verification
The hardest case to provoke is a mix of lanes inside one operand pair: some overflow, some stay in range, and some sit exactly on a limit. This mix is what shows that clamping and wrapping act per lane, and that no carry leaks into the next lane. The stimulus puts hand-built patterns into single lanes, such as 0x7F+0x01, 0x80-0x01, 0xFF+0x01 and 0x00-0x01, next to in-range lanes. A pseudo-random sweep then crosses every legal op/size/mode setting, and its operands are sometimes forced equal so that compares hit the equality boundary.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_CEQ = 2'd2, OP_CGT = 2'd3} op_e;
    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2, SZ_RSVD = 2'd3} size_e;
    typedef enum logic [1:0] {MD_WRAP = 2'd0, MD_SSAT = 2'd1, MD_USAT = 2'd2, MD_RSVD = 2'd3} mode_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [DATA_W-1:0] res;
    } out_st_t;
endpackage

// File: rtl/simd_lane_calc.sv
module simd_lane_calc
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  op_e          op_i,
    input  mode_e        mode_i,
    output logic [W-1:0] r_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_d, dif_d;
    logic       s_ovf_add, s_ovf_sub;

    always_comb begin
        sum_d     = {1'b0, a_i} + {1'b0, b_i};
        dif_d     = {1'b0, a_i} - {1'b0, b_i};
        s_ovf_add = (a_i[W-1] == b_i[W-1]) && (sum_d[W-1] != a_i[W-1]);
        s_ovf_sub = (a_i[W-1] != b_i[W-1]) && (dif_d[W-1] != a_i[W-1]);
        r_o       = '0;
        unique case (op_i)
            OP_ADD: begin
                r_o = sum_d[W-1:0];
                if (mode_i == MD_SSAT && s_ovf_add) r_o = a_i[W-1] ? SMIN : SMAX;
                if (mode_i == MD_USAT && sum_d[W])  r_o = '1;
            end
            OP_SUB: begin
                r_o = dif_d[W-1:0];
                if (mode_i == MD_SSAT && s_ovf_sub) r_o = a_i[W-1] ? SMIN : SMAX;
                if (mode_i == MD_USAT && dif_d[W])  r_o = '0;
            end
            OP_CEQ: r_o = (a_i == b_i) ? '1 : '0;
            OP_CGT: r_o = ($signed(a_i) > $signed(b_i)) ? '1 : '0;
            default: r_o = '0;
        endcase
    end
endmodule

// File: rtl/simd_alu_core.sv
module simd_alu_core
    import simd_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  op_e               op_i,
    input  size_e             size_i,
    input  mode_e             mode_i,
    output logic [DATA_W-1:0] res_o,
    output logic              illegal_o
);
    localparam int NB = DATA_W / 8;
    localparam int NW = DATA_W / 16;
    localparam int ND = DATA_W / 32;

    logic [DATA_W-1:0] res_b, res_w, res_d;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        simd_lane_calc #(.W(8)) u_lane (
            .a_i(a_i[g*8 +: 8]), .b_i(b_i[g*8 +: 8]),
            .op_i(op_i), .mode_i(mode_i), .r_o(res_b[g*8 +: 8]));
    end
    for (genvar g = 0; g < NW; g++) begin : g_word
        simd_lane_calc #(.W(16)) u_lane (
            .a_i(a_i[g*16 +: 16]), .b_i(b_i[g*16 +: 16]),
            .op_i(op_i), .mode_i(mode_i), .r_o(res_w[g*16 +: 16]));
    end
    for (genvar g = 0; g < ND; g++) begin : g_dword
        simd_lane_calc #(.W(32)) u_lane (
            .a_i(a_i[g*32 +: 32]), .b_i(b_i[g*32 +: 32]),
            .op_i(op_i), .mode_i(mode_i), .r_o(res_d[g*32 +: 32]));
    end

    always_comb begin
        illegal_o = (size_i == SZ_RSVD) || (mode_i == MD_RSVD) ||
                    (size_i == SZ_D && mode_i != MD_WRAP);
        unique case (size_i)
            SZ_B:    res_o = res_b;
            SZ_W:    res_o = res_w;
            SZ_D:    res_o = res_d;
            default: res_o = '0;
        endcase
        if (illegal_o) res_o = '0;
    end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
    import simd_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  op,
    input  logic [1:0]  size,
    input  logic [1:0]  mode,
    input  logic [63:0] a,
    input  logic [63:0] b,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        illegal_op
);
    logic [DATA_W-1:0] core_res;
    logic              core_ill;
    out_st_t           st_d, st_q;

    simd_alu_core u_core (
        .a_i(a), .b_i(b),
        .op_i(op_e'(op)), .size_i(size_e'(size)), .mode_i(mode_e'(mode)),
        .res_o(core_res), .illegal_o(core_ill));

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res     = core_res;
            st_d.illegal = core_ill;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign result     = st_q.res;
    assign illegal_op = st_q.illegal;

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (result == '0));
    assert_dword_clamp_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'd2 && mode != 2'd0) |=> illegal_op);
    assert_add_zero_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && mode == 2'd0 && size != 2'd3 && b == '0) |=> (result == $past(a)));
    assert_usat_add_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && mode == 2'd2 && size[1] == 1'b0 && a == '1) |=> (result == '1));
endmodule

// File: tb/tb_simd_sat_alu.sv
module tb_simd_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0, size = '0, mode = '0;
    logic [63:0] a = '0, b = '0;
    logic        out_valid, illegal_op;
    logic [63:0] result;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [64:0] expq[$];
    string       tagq[$];
    logic [63:0] last_res = '0;

    always #5 clk = ~clk;

    simd_sat_alu dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .mode(mode), .a(a), .b(b), .out_valid(out_valid), .result(result), .illegal_op(illegal_op));

    function automatic logic [64:0] model(input logic [1:0] o, input logic [1:0] s,
                                          input logic [1:0] m, input logic [63:0] x, input logic [63:0] y);
        logic [63:0] r = '0;
        int w;
        longint msk, smax, smin;
        if (s == 2'd3 || m == 2'd3 || (s == 2'd2 && m != 2'd0)) return {1'b1, 64'd0};
        w = 8 << s;
        msk = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -(longint'(1) << (w - 1));
        for (int i = 0; i < 64 / w; i++) begin
            longint ux, uy, sx, sy, t;
            ux = longint'((x >> (i * w))) & msk;
            uy = longint'((y >> (i * w))) & msk;
            sx = (ux > smax) ? ux - msk - 1 : ux;
            sy = (uy > smax) ? uy - msk - 1 : uy;
            case (o)
                2'd0: begin
                    if (m == 2'd1) begin t = sx + sy; t = (t > smax) ? smax : (t < smin) ? smin : t; end
                    else if (m == 2'd2) t = (ux + uy > msk) ? msk : ux + uy;
                    else t = ux + uy;
                end
                2'd1: begin
                    if (m == 2'd1) begin t = sx - sy; t = (t > smax) ? smax : (t < smin) ? smin : t; end
                    else if (m == 2'd2) t = (ux < uy) ? 0 : ux - uy;
                    else t = ux - uy;
                end
                2'd2: t = (ux == uy) ? msk : 0;
                default: t = (sx > sy) ? msk : 0;
            endcase
            r = r | ((64'(t) & 64'(msk)) << (i * w));
        end
        return {1'b0, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] o, input logic [1:0] s, input logic [1:0] m,
                        input logic [63:0] x, input logic [63:0] y, input string tag);
        logic [64:0] e;
        @(negedge clk);
        in_valid = 1'b1; op = o; size = s; mode = m; a = x; b = y;
        e = model(o, s, m, x, y);
        expq.push_back(e);
        tagq.push_back(tag);
        last_res = e[63:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a = ~a; b = b + 64'd3;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected out_valid", {illegal_op, result}, 65'd0);
            end else begin
                logic [64:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({illegal_op, result} === e, t, {illegal_op, result}, e);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        longint unsigned rs = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(negedge clk);
        check({out_valid, illegal_op, result} === 66'd0, "R10 in reset", {illegal_op, result}, 65'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_valid, illegal_op, result} === 66'd0, "R10 after reset", {illegal_op, result}, 65'd0);

        // R1 wrap add: lane 0 overflows, lane 1 must not see a carry
        send(2'd0, 2'd0, 2'd0, 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_0001, "R1 byte wrap");
        send(2'd0, 2'd1, 2'd0, 64'h0000_0000_1234_FFFF, 64'h0000_0000_0001_0002, "R1 word wrap");
        send(2'd0, 2'd2, 2'd0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, "R1 dword wrap");
        // R2 wrap subtract: borrow must stay in its lane
        send(2'd1, 2'd0, 2'd0, 64'h0000_0000_0000_0500, 64'h0000_0000_0000_0001, "R2 byte wrap");
        send(2'd1, 2'd2, 2'd0, 64'h0000_0005_0000_0000, 64'h0000_0000_0000_0001, "R2 dword wrap");
        // R3 signed clamp at both limits, mixed with in-range lanes
        send(2'd0, 2'd0, 2'd1, 64'h1080_7F7F_0102_8080, 64'h2080_0101_0304_FF01, "R3 byte add");
        send(2'd1, 2'd0, 2'd1, 64'h0000_0000_807F_8010, 64'h0000_0000_01FF_0105, "R3 byte sub");
        send(2'd0, 2'd1, 2'd1, 64'h7FFF_8000_1000_7FFE, 64'h0001_FFFF_2000_0001, "R3 word add");
        // R4 / R5 unsigned clamps
        send(2'd0, 2'd0, 2'd2, 64'h0000_0000_10FE_FFFF, 64'h0000_0000_2001_0101, "R4 byte add");
        send(2'd0, 2'd1, 2'd2, 64'h0000_0000_FFFF_8000, 64'h0000_0000_0001_8000, "R4 word add");
        send(2'd1, 2'd0, 2'd2, 64'h0000_0000_0510_0000, 64'h0000_0000_0320_0001, "R5 byte sub");
        send(2'd1, 2'd1, 2'd2, 64'h0000_0000_0001_1234, 64'h0000_0000_0002_1234, "R5 word sub");
        // R6 equality, mode ignored when legal
        send(2'd2, 2'd0, 2'd1, 64'h1122_3344_5566_7788, 64'h1122_0044_5566_7700, "R6 byte eq");
        send(2'd2, 2'd2, 2'd0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0002, "R6 dword eq");
        // R7 signed greater
        send(2'd3, 2'd0, 2'd0, 64'h0180_7F00_FF01_0000, 64'h00FF_8001_0000_0000, "R7 byte gt");
        send(2'd3, 2'd1, 2'd2, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_FFFE, "R7 word gt");
        // R8 illegal combinations
        send(2'd0, 2'd2, 2'd1, 64'h7FFF_FFFF_7FFF_FFFF, 64'h1, "R8 dword signed clamp");
        send(2'd1, 2'd2, 2'd2, 64'h5, 64'h9, "R8 dword unsigned clamp");
        send(2'd0, 2'd3, 2'd0, 64'h5, 64'h9, "R8 size 3");
        send(2'd0, 2'd0, 2'd3, 64'h5, 64'h9, "R8 mode 3");
        send(2'd0, 2'd1, 2'd0, 64'h0001_0002_0003_0004, 64'h0, "R8 legal clears flag");
        idle(3);
        check(out_valid === 1'b0 && result === last_res, "R9 hold while idle",
              {out_valid, result}, {1'b0, last_res});

        for (int i = 0; i < 360; i++) begin
            logic [63:0] x, y;
            logic [1:0] s, m;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
            x = rs;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
            y = (i % 5 == 0) ? x ^ (rs & 64'h00FF_0000_0000_FF00) : rs;
            s = 2'((i / 4) % 3);
            m = (s == 2'd2) ? 2'd0 : 2'((i / 12) % 3);
            send(2'(i % 4), s, m, x, y, "R1 R2 R3 R4 R5 R6 R7 sweep");
            if (i % 37 == 0) idle(1);
        end
        idle(4);
        check(expq.size() == 0, "R9 all results delivered", 65'(expq.size()), 65'd0);
        finish_run();
    end
endmodule